// File: doc/BRIEF.md
# Shared Configuration Register Gate

This block holds the identification and interrupt configuration that a device presents to an external host over PCI Type 0 configuration cycles. Two requesters reach the same storage. The local side is on-chip software. The host side is the external master, which arrives through a PCI target engine placed in front of this block. The block stores:

- the subsystem ID;
- override values for the vendor/device ID word and the class/revision word;
- a set of address-map entries;
- a scratch word;
- an interrupt bit that pulls an active-low interrupt pin low.

A write-only control register holds a hold-off bit. This bit is set at reset. While it is set, every host configuration read is answered with a retry instead of data, so the host cannot see identification values before local software has programmed them. While the bit is set, the local side may also rewrite the identification and map registers. When software clears the bit, those registers are locked against further change and host reads complete normally. Software can set the bit again to reopen both the lock and the hold-off.

Each port is a valid/ready request stream:

- A request is taken on a clock edge where valid and ready are both high.
- The local port is always ready.
- The host port drops ready in any cycle where the local port presents a request. The host then holds its request until it is taken.
- Responses carry no back-pressure. Every taken request, read or write, produces a one-cycle response pulse in the cycle after it is taken. A write response carries zero data.

Top module: `cfg_gate`

## Requirements
- R1: After reset, the hold-off bit is set, the interrupt bit is clear (intr_oe low), the subsystem ID and scratch words read 0, the ID word reads ID_RESET, the class word reads CLASS_RESET, and no response is pending.
- R2: lc_ready is always high. hs_ready is low in every cycle where lc_valid is high, so that when both ports request in the same cycle the local request is served first and the host request is taken in a later cycle.
- R3: A request taken on clock edge N produces exactly one response pulse (rsp_valid high) on the same port, visible in the cycle after edge N. A write response carries data 0.
- R4: While the hold-off bit is set, every host read is answered with hs_rsp_retry=1 and data 0, whatever the address.
- R5: While the hold-off bit is clear, host reads of ID (address 0x0), class (0x1) and subsystem (0x2) return the stored words with hs_rsp_retry=0.
- R6: Host writes to ID, class, subsystem, interrupt (0x3), control (0x4) and map (0x8 to 0x8+MAP_N-1) change nothing. Host reads of interrupt, control and map return 0.
- R7: Local writes to ID, class, subsystem and map entries take effect only while the hold-off bit is set. While it is clear they are ignored.
- R8: The control register at 0x4 uses wdata bit 0 as the hold-off bit. Only a local write changes it, and reads of 0x4 return 0 on both ports.
- R9: The interrupt register at 0x3 uses bit 0. A local write may change it at any time, and a local read returns it. While it is set, intr_oe is 1 and intr_n is driven 0. While it is clear, intr_oe is 0 and intr_n is released to high impedance.
- R10: The scratch word at 0x5 can be written and read by both ports. Host writes to it are accepted even while host reads are held off.
- R11: The MAP_N map entries at 0x8 onward are stored independently and can be read back by the local port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lc_valid | input | 1 | Local request valid |
| lc_ready | output | 1 | Local request ready (always 1) |
| lc_write | input | 1 | Local request is a write |
| lc_addr | input | AW | Local word address |
| lc_wdata | input | DW | Local write data |
| lc_rsp_valid | output | 1 | Local response pulse |
| lc_rsp_data | output | DW | Local read data |
| hs_valid | input | 1 | Host request valid |
| hs_ready | output | 1 | Host request ready |
| hs_write | input | 1 | Host request is a write |
| hs_addr | input | AW | Host word address |
| hs_wdata | input | DW | Host write data |
| hs_rsp_valid | output | 1 | Host response pulse |
| hs_rsp_data | output | DW | Host read data |
| hs_rsp_retry | output | 1 | Host read refused, retry later |
| intr_oe | output | 1 | Interrupt pin drive enable |
| intr_n | output | 1 | Active-low interrupt, high impedance when idle |

## Verification
The assertions assume each requester keeps valid and its request fields steady until the request is taken. They also assume reset is held for at least one clock edge before any request is made. Both assertions on response timing depend on these assumptions. The bench drives every request on the falling edge and holds it until ready has been seen high. It releases the request only after the taking edge, and it holds reset across several edges with both valids low. One scenario deliberately raises both valids in the same cycle, to exercise the local-first rule while keeping the host request stable during its stall.

// File: rtl/cfg_gate_pkg.sv
package cfg_gate_pkg;
  localparam int unsigned OFS_ID      = 0;
  localparam int unsigned OFS_CLASS   = 1;
  localparam int unsigned OFS_SUBSYS  = 2;
  localparam int unsigned OFS_INTR    = 3;
  localparam int unsigned OFS_CTRL    = 4;
  localparam int unsigned OFS_SCRATCH = 5;
  localparam int unsigned OFS_MAP     = 8;

  typedef enum logic {SRC_LOCAL = 1'b0, SRC_HOST = 1'b1} src_e;
endpackage

// File: rtl/cfg_gate_arb.sv
module cfg_gate_arb
  import cfg_gate_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 32
) (
  input  logic          lc_valid,
  input  logic          lc_write,
  input  logic [AW-1:0] lc_addr,
  input  logic [DW-1:0] lc_wdata,
  input  logic          hs_valid,
  input  logic          hs_write,
  input  logic [AW-1:0] hs_addr,
  input  logic [DW-1:0] hs_wdata,
  output logic          lc_ready,
  output logic          hs_ready,
  output logic          acc_valid,
  output src_e          acc_src,
  output logic          acc_write,
  output logic [AW-1:0] acc_addr,
  output logic [DW-1:0] acc_wdata
);
  // The local side always wins; the host waits out any cycle with a local request.
  assign lc_ready = 1'b1;
  assign hs_ready = !lc_valid;

  always_comb begin
    acc_valid = lc_valid || hs_valid;
    if (lc_valid) begin
      acc_src   = SRC_LOCAL;
      acc_write = lc_write;
      acc_addr  = lc_addr;
      acc_wdata = lc_wdata;
    end else begin
      acc_src   = SRC_HOST;
      acc_write = hs_write;
      acc_addr  = hs_addr;
      acc_wdata = hs_wdata;
    end
  end
endmodule

// File: rtl/cfg_gate_regs.sv
module cfg_gate_regs
  import cfg_gate_pkg::*;
#(
  parameter int unsigned AW          = 4,
  parameter int unsigned DW          = 32,
  parameter int unsigned MAP_N       = 4,
  parameter logic [DW-1:0] ID_RESET    = '0,
  parameter logic [DW-1:0] CLASS_RESET = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  src_e          acc_src,
  input  logic          acc_write,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] acc_wdata,
  output logic [DW-1:0] rd_data,
  output logic          holdoff,
  output logic          intr_bit
);
  localparam int unsigned MIW = (MAP_N > 1) ? $clog2(MAP_N) : 1;

  logic [DW-1:0] id_q, class_q, subsys_q, scratch_q;
  logic [DW-1:0] map_q [MAP_N];
  logic          hold_q, intr_q;

  logic is_id, is_class, is_subsys, is_intr, is_ctrl, is_scratch, is_map;
  logic [AW-1:0]  map_ofs;
  logic [MIW-1:0] map_idx;
  logic wr, wr_local, wr_ident;

  always_comb begin
    is_id      = acc_addr == AW'(OFS_ID);
    is_class   = acc_addr == AW'(OFS_CLASS);
    is_subsys  = acc_addr == AW'(OFS_SUBSYS);
    is_intr    = acc_addr == AW'(OFS_INTR);
    is_ctrl    = acc_addr == AW'(OFS_CTRL);
    is_scratch = acc_addr == AW'(OFS_SCRATCH);
    is_map     = (acc_addr >= AW'(OFS_MAP)) && (acc_addr < AW'(OFS_MAP + MAP_N));
    map_ofs    = acc_addr - AW'(OFS_MAP);
    map_idx    = map_ofs[MIW-1:0];
    wr         = acc_valid && acc_write;
    wr_local   = wr && (acc_src == SRC_LOCAL);
    // Identification and map words accept local writes only during hold-off.
    wr_ident   = wr_local && hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q      <= ID_RESET;
      class_q   <= CLASS_RESET;
      subsys_q  <= '0;
      scratch_q <= '0;
      hold_q    <= 1'b1;
      intr_q    <= 1'b0;
    end else begin
      if (wr_ident && is_id)     id_q     <= acc_wdata;
      if (wr_ident && is_class)  class_q  <= acc_wdata;
      if (wr_ident && is_subsys) subsys_q <= acc_wdata;
      if (wr_local && is_intr)   intr_q   <= acc_wdata[0];
      if (wr_local && is_ctrl)   hold_q   <= acc_wdata[0];
      if (wr && is_scratch)      scratch_q <= acc_wdata;
    end
  end

  for (genvar g = 0; g < MAP_N; g++) begin : g_map
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) map_q[g] <= '0;
      else if (wr_ident && is_map && (map_idx == MIW'(g))) map_q[g] <= acc_wdata;
    end
  end

  always_comb begin
    rd_data = '0;
    if (is_id)           rd_data = id_q;
    else if (is_class)   rd_data = class_q;
    else if (is_subsys)  rd_data = subsys_q;
    else if (is_scratch) rd_data = scratch_q;
    else if (acc_src == SRC_LOCAL) begin
      if (is_intr)       rd_data = {{(DW-1){1'b0}}, intr_q};
      else if (is_map)   rd_data = map_q[map_idx];
    end
  end

  assign holdoff  = hold_q;
  assign intr_bit = intr_q;
endmodule

// File: rtl/cfg_gate_rsp.sv
module cfg_gate_rsp
  import cfg_gate_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  src_e          acc_src,
  input  logic          acc_write,
  input  logic          holdoff,
  input  logic [DW-1:0] rd_data,
  output logic          lc_rsp_valid,
  output logic [DW-1:0] lc_rsp_data,
  output logic          hs_rsp_valid,
  output logic [DW-1:0] hs_rsp_data,
  output logic          hs_rsp_retry
);
  logic          rv_q [2];
  logic [DW-1:0] rd_q [2];
  logic          refuse;

  assign refuse = (acc_src == SRC_HOST) && !acc_write && holdoff;

  for (genvar p = 0; p < 2; p++) begin : g_port
    logic hit;
    assign hit = acc_valid && (acc_src == src_e'(p));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rv_q[p] <= 1'b0;
        rd_q[p] <= '0;
      end else begin
        rv_q[p] <= hit;
        if (hit) rd_q[p] <= (acc_write || refuse) ? '0 : rd_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hs_rsp_retry <= 1'b0;
    else        hs_rsp_retry <= acc_valid && refuse;
  end

  assign lc_rsp_valid = rv_q[0];
  assign lc_rsp_data  = rd_q[0];
  assign hs_rsp_valid = rv_q[1];
  assign hs_rsp_data  = rd_q[1];
endmodule

// File: rtl/cfg_gate.sv
module cfg_gate
  import cfg_gate_pkg::*;
#(
  parameter int unsigned AW          = 4,
  parameter int unsigned DW          = 32,
  parameter int unsigned MAP_N       = 4,
  parameter logic [DW-1:0] ID_RESET    = 32'h1A2B_3C4D,
  parameter logic [DW-1:0] CLASS_RESET = 32'h0580_0001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lc_valid,
  output logic          lc_ready,
  input  logic          lc_write,
  input  logic [AW-1:0] lc_addr,
  input  logic [DW-1:0] lc_wdata,
  output logic          lc_rsp_valid,
  output logic [DW-1:0] lc_rsp_data,
  input  logic          hs_valid,
  output logic          hs_ready,
  input  logic          hs_write,
  input  logic [AW-1:0] hs_addr,
  input  logic [DW-1:0] hs_wdata,
  output logic          hs_rsp_valid,
  output logic [DW-1:0] hs_rsp_data,
  output logic          hs_rsp_retry,
  output logic          intr_oe,
  output wire           intr_n
);
  logic          acc_valid, acc_write;
  src_e          acc_src;
  logic [AW-1:0] acc_addr;
  logic [DW-1:0] acc_wdata, rd_data;
  logic          holdoff, intr_bit;

  cfg_gate_arb #(.AW(AW), .DW(DW)) u_arb (
    .lc_valid(lc_valid), .lc_write(lc_write), .lc_addr(lc_addr), .lc_wdata(lc_wdata),
    .hs_valid(hs_valid), .hs_write(hs_write), .hs_addr(hs_addr), .hs_wdata(hs_wdata),
    .lc_ready(lc_ready), .hs_ready(hs_ready),
    .acc_valid(acc_valid), .acc_src(acc_src), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata)
  );

  cfg_gate_regs #(.AW(AW), .DW(DW), .MAP_N(MAP_N),
                  .ID_RESET(ID_RESET), .CLASS_RESET(CLASS_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_src(acc_src), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rd_data(rd_data), .holdoff(holdoff), .intr_bit(intr_bit)
  );

  cfg_gate_rsp #(.DW(DW)) u_rsp (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_src(acc_src), .acc_write(acc_write),
    .holdoff(holdoff), .rd_data(rd_data),
    .lc_rsp_valid(lc_rsp_valid), .lc_rsp_data(lc_rsp_data),
    .hs_rsp_valid(hs_rsp_valid), .hs_rsp_data(hs_rsp_data),
    .hs_rsp_retry(hs_rsp_retry)
  );

  assign intr_oe = intr_bit;
  assign intr_n  = intr_bit ? 1'b0 : 1'bz;
endmodule

// File: rtl/cfg_gate_chk.sv
module cfg_gate_chk
  import cfg_gate_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lc_valid,
  input logic          lc_ready,
  input logic          lc_write,
  input logic [AW-1:0] lc_addr,
  input logic [DW-1:0] lc_wdata,
  input logic          lc_rsp_valid,
  input logic [DW-1:0] lc_rsp_data,
  input logic          hs_valid,
  input logic          hs_ready,
  input logic          hs_write,
  input logic          hs_rsp_valid,
  input logic [DW-1:0] hs_rsp_data,
  input logic          hs_rsp_retry,
  input logic          intr_oe,
  input logic          holdoff
);
  logic lc_take, hs_take, lc_ctrl_wr;
  assign lc_take    = lc_valid && lc_ready;
  assign hs_take    = hs_valid && hs_ready;
  assign lc_ctrl_wr = lc_take && lc_write && (lc_addr == AW'(OFS_CTRL));

  AST_LOCAL_READY:  assert property (@(posedge clk) disable iff (!rst_n) lc_ready);                       // R2
  AST_HOST_YIELDS:  assert property (@(posedge clk) disable iff (!rst_n) lc_valid |-> !hs_ready);         // R2
  AST_LC_RSP_NEXT:  assert property (@(posedge clk) disable iff (!rst_n) lc_take |=> lc_rsp_valid);       // R3
  AST_HS_RSP_NEXT:  assert property (@(posedge clk) disable iff (!rst_n) hs_take |=> hs_rsp_valid);       // R3
  AST_HS_NO_SPUR:   assert property (@(posedge clk) disable iff (!rst_n) !hs_take |=> !hs_rsp_valid);     // R3
  AST_RETRY_HELD:   assert property (@(posedge clk) disable iff (!rst_n)
                      (hs_take && !hs_write && holdoff) |=> (hs_rsp_retry && hs_rsp_data == '0));         // R4
  AST_RETRY_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) hs_rsp_retry |-> hs_rsp_valid);  // R4
  AST_HOLD_LOCAL:   assert property (@(posedge clk) disable iff (!rst_n) !lc_ctrl_wr |=> $stable(holdoff)); // R8
  AST_CTRL_ZERO:    assert property (@(posedge clk) disable iff (!rst_n)
                      (lc_take && !lc_write && lc_addr == AW'(OFS_CTRL)) |=> lc_rsp_data == '0);          // R8
  AST_INTR_SET:     assert property (@(posedge clk) disable iff (!rst_n)
                      (lc_take && lc_write && lc_addr == AW'(OFS_INTR)) |=> (intr_oe == $past(lc_wdata[0]))); // R9
endmodule

bind cfg_gate cfg_gate_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .lc_valid(lc_valid), .lc_ready(lc_ready), .lc_write(lc_write), .lc_addr(lc_addr),
  .lc_wdata(lc_wdata), .lc_rsp_valid(lc_rsp_valid), .lc_rsp_data(lc_rsp_data),
  .hs_valid(hs_valid), .hs_ready(hs_ready), .hs_write(hs_write),
  .hs_rsp_valid(hs_rsp_valid), .hs_rsp_data(hs_rsp_data), .hs_rsp_retry(hs_rsp_retry),
  .intr_oe(intr_oe), .holdoff(holdoff)
);

// File: tb/tb_cfg_gate.sv
`timescale 1ns/1ps
module tb_cfg_gate;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam logic [DW-1:0] IDR = 32'h1A2B_3C4D;
  localparam logic [DW-1:0] CLR = 32'h0580_0001;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lc_valid = 0, lc_write = 0, hs_valid = 0, hs_write = 0;
  logic [AW-1:0] lc_addr = '0, hs_addr = '0;
  logic [DW-1:0] lc_wdata = '0, hs_wdata = '0;
  logic lc_ready, hs_ready, lc_rsp_valid, hs_rsp_valid, hs_rsp_retry, intr_oe;
  logic [DW-1:0] lc_rsp_data, hs_rsp_data;
  wire intr_n;

  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cfg_gate dut (
    .clk(clk), .rst_n(rst_n),
    .lc_valid(lc_valid), .lc_ready(lc_ready), .lc_write(lc_write), .lc_addr(lc_addr),
    .lc_wdata(lc_wdata), .lc_rsp_valid(lc_rsp_valid), .lc_rsp_data(lc_rsp_data),
    .hs_valid(hs_valid), .hs_ready(hs_ready), .hs_write(hs_write), .hs_addr(hs_addr),
    .hs_wdata(hs_wdata), .hs_rsp_valid(hs_rsp_valid), .hs_rsp_data(hs_rsp_data),
    .hs_rsp_retry(hs_rsp_retry), .intr_oe(intr_oe), .intr_n(intr_n)
  );

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic lc_op(bit wr, logic [AW-1:0] a, logic [DW-1:0] d, output logic [DW-1:0] rd);
    @(negedge clk);
    lc_valid = 1; lc_write = wr; lc_addr = a; lc_wdata = d;
    @(posedge clk); #1;
    chk("R3 local rsp", {31'd0, lc_rsp_valid}, 1);
    rd = lc_rsp_data;
    @(negedge clk); lc_valid = 0;
  endtask

  task automatic hs_op(bit wr, logic [AW-1:0] a, logic [DW-1:0] d,
                       output logic [DW-1:0] rd, output logic rt);
    @(negedge clk);
    hs_valid = 1; hs_write = wr; hs_addr = a; hs_wdata = d;
    #1;
    while (!hs_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    chk("R3 host rsp", {31'd0, hs_rsp_valid}, 1);
    rd = hs_rsp_data; rt = hs_rsp_retry;
    @(negedge clk); hs_valid = 0;
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    #1;
    chk("R1 intr_oe", {31'd0, intr_oe}, 0);
    chk("R1 no lc rsp", {31'd0, lc_rsp_valid}, 0);
    chk("R1 no hs rsp", {31'd0, hs_rsp_valid}, 0);
    chk("R2 hs_ready idle", {31'd0, hs_ready}, 1);
    lc_op(0, 4'h0, 0, v); chk("R1 id reset", v, IDR);
    lc_op(0, 4'h1, 0, v); chk("R1 class reset", v, CLR);
    lc_op(0, 4'h2, 0, v); chk("R1 subsys reset", v, 0);
    lc_op(0, 4'h5, 0, v); chk("R1 scratch reset", v, 0);
  endtask

  task automatic t_holdoff_reads();
    logic [DW-1:0] v; logic r;
    hs_op(0, 4'h2, 0, v, r);
    chk("R4 retry flag", {31'd0, r}, 1); chk("R4 retry data", v, 0);
    hs_op(0, 4'h0, 0, v, r);
    chk("R4 retry on id", {31'd0, r}, 1);
  endtask

  task automatic t_local_setup();
    logic [DW-1:0] v;
    lc_op(1, 4'h2, 32'hCAFE_F00D, v); chk("R3 write rsp zero", v, 0);
    lc_op(0, 4'h2, 0, v); chk("R7 subsys written in holdoff", v, 32'hCAFE_F00D);
    lc_op(1, 4'h1, 32'h0C03_0010, v);
    lc_op(1, 4'h9, 32'h0000_9999, v);
    lc_op(1, 4'hB, 32'h0000_BBBB, v);
    lc_op(0, 4'h9, 0, v); chk("R11 map1", v, 32'h0000_9999);
    lc_op(0, 4'hB, 0, v); chk("R11 map3", v, 32'h0000_BBBB);
    lc_op(0, 4'h8, 0, v); chk("R11 map0 untouched", v, 0);
  endtask

  task automatic t_release();
    logic [DW-1:0] v; logic r;
    lc_op(1, 4'h4, 32'h0, v);
    lc_op(0, 4'h4, 0, v); chk("R8 ctrl reads zero", v, 0);
    hs_op(0, 4'h2, 0, v, r);
    chk("R5 no retry", {31'd0, r}, 0); chk("R5 subsys", v, 32'hCAFE_F00D);
    hs_op(0, 4'h0, 0, v, r); chk("R5 id", v, IDR);
    hs_op(0, 4'h1, 0, v, r); chk("R5 class", v, 32'h0C03_0010);
    hs_op(0, 4'h4, 0, v, r); chk("R8 host ctrl read zero", v, 0);
  endtask

  task automatic t_lock();
    logic [DW-1:0] v;
    lc_op(1, 4'h0, 32'hDEAD_0000, v);
    lc_op(0, 4'h0, 0, v); chk("R7 id locked", v, IDR);
    lc_op(1, 4'h9, 32'h1111, v);
    lc_op(0, 4'h9, 0, v); chk("R7 map locked", v, 32'h0000_9999);
  endtask

  task automatic t_host_ignored();
    logic [DW-1:0] v; logic r;
    hs_op(1, 4'h2, 32'h1234, v, r);
    hs_op(0, 4'h2, 0, v, r); chk("R6 host subsys write ignored", v, 32'hCAFE_F00D);
    hs_op(1, 4'h4, 32'h1, v, r);
    hs_op(0, 4'h0, 0, v, r); chk("R6 host ctrl write ignored", {31'd0, r}, 0);
    hs_op(0, 4'h9, 0, v, r); chk("R6 host map read zero", v, 0);
    hs_op(1, 4'h9, 32'h7777, v, r);
    lc_op(0, 4'h9, 0, v); chk("R6 host map write ignored", v, 32'h0000_9999);
  endtask

  task automatic t_intr();
    logic [DW-1:0] v; logic r;
    lc_op(1, 4'h3, 32'h1, v);
    chk("R9 oe set", {31'd0, intr_oe}, 1);
    chk("R9 pin low", {31'd0, intr_n}, 0);
    lc_op(0, 4'h3, 0, v); chk("R9 readback", v, 1);
    hs_op(0, 4'h3, 0, v, r); chk("R6 host intr read zero", v, 0);
    hs_op(1, 4'h3, 32'h0, v, r);
    chk("R6 host intr write ignored", {31'd0, intr_oe}, 1);
    lc_op(1, 4'h3, 32'h0, v);
    chk("R9 oe clear", {31'd0, intr_oe}, 0);
  endtask

  task automatic t_priority();
    logic [DW-1:0] v;
    @(negedge clk);
    lc_valid = 1; lc_write = 1; lc_addr = 4'h5; lc_wdata = 32'hAAAA;
    hs_valid = 1; hs_write = 1; hs_addr = 4'h5; hs_wdata = 32'hBBBB;
    #1;
    chk("R2 host stalled", {31'd0, hs_ready}, 0);
    chk("R2 local ready", {31'd0, lc_ready}, 1);
    @(posedge clk); #1;
    chk("R2 local first", {31'd0, lc_rsp_valid}, 1);
    chk("R2 host not yet", {31'd0, hs_rsp_valid}, 0);
    @(negedge clk); lc_valid = 0; #1;
    chk("R2 host ready after", {31'd0, hs_ready}, 1);
    @(posedge clk); #1;
    chk("R3 host rsp after stall", {31'd0, hs_rsp_valid}, 1);
    @(negedge clk); hs_valid = 0;
    lc_op(0, 4'h5, 0, v); chk("R10 host write lands last", v, 32'hBBBB);
  endtask

  task automatic t_rearm();
    logic [DW-1:0] v; logic r;
    lc_op(1, 4'h4, 32'h1, v);
    hs_op(1, 4'h5, 32'h5555, v, r);
    lc_op(0, 4'h5, 0, v); chk("R10 host write in holdoff", v, 32'h5555);
    hs_op(0, 4'h5, 0, v, r); chk("R8 rearmed retry", {31'd0, r}, 1);
    lc_op(1, 4'h0, 32'h0BAD_CAFE, v);
    lc_op(0, 4'h0, 0, v); chk("R7 id writable again", v, 32'h0BAD_CAFE);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset();
    t_holdoff_reads();
    t_local_setup();
    t_release();
    t_lock();
    t_host_ignored();
    t_intr();
    t_priority();
    t_rearm();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule